// File: doc/BRIEF.md
# Serializer-Fed Parallel PWM Generator

This block produces a pulse-width modulated waveform whose time resolution is one serializer bit time, not one fabric clock. Every fabric clock it emits a word of `RATIO` bits. Each bit covers one fine time step, and an output serializer or DDR stage shifts the word out lowest index first. A full PWM period spans `PERIOD` fine steps. This takes `PERIOD / RATIO` fabric clocks, and `PERIOD` must be a whole multiple of `RATIO`.

A period counter advances by `RATIO` steps per clock. Each bit lane compares the held duty value against its own fine-step position within the period. The duty value can be written at any time, but it is taken into use only at the period boundary, so the waveform never glitches mid-period. Within a period the output is low for its first `PERIOD - duty` fine steps and high for the rest. A parameter selects a down-counting or an up-counting period counter, and the two give identical output.

Top module: `ser_pwm_gen`

## Requirements
- R1: While `rst` is high, `pwm_word` reads all zero on the clock after each reset edge. The held duty clears to 0, so the first full period after reset is all zero whatever `duty_in` holds.
- R2: Number the fine steps of a period j = 0 .. PERIOD-1 in time order, where word w of the period carries steps w*RATIO + k in lane k and bit 0 is the earliest. Lane k is then high exactly when j >= PERIOD - D, with D the held duty. Within a word the lanes form a thermometer that fills from the top index downward.
- R3: The number of high bits emitted in one period equals min(D, PERIOD).
- R4: `duty_in` is sampled only on the clock that emits the last word of a period, and only if `load_en` is high then. It applies from the next period on, and changes at any other time do not alter the current period.
- R5: If `load_en` is low on the last-word clock, the previously held duty stays in force for the next period.
- R6: A held duty of 0 gives all-zero words. A held duty equal to `PERIOD` gives all-one words.
- R7: A held duty above `PERIOD` behaves like `PERIOD`, which gives all-one words.
- R8: The up-counting variant (`DIR = CNT_UP`) gives output identical to the down-counting variant for the same inputs.
- R9: Ratios that are not powers of two, for example 5 with a period of 250, follow R2 and R3 unchanged.
- R10: A period lasts exactly PERIOD/RATIO clocks. The duty sample point recurs every PERIOD/RATIO clocks, counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one output word per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | DUTY_W | Requested high time in fine steps, default width clog2(PERIOD+1) |
| load_en | input | 1 | Allows `duty_in` to be taken at the next period boundary |
| pwm_word | output | RATIO | Parallel word for the serializer, bit 0 sent first |

## Verification
The output word is registered once. The word for period position w therefore appears one clock after the counter holds w, and a duty sampled on the last-word clock first shows in the word emitted two clocks later. The bench reference model updates on each rising edge and stores the word the design must present after that edge. Outputs are compared on the following falling edge, so the reference and the design always refer to the same clock. Per-period high-bit totals are summed from the same sampled words and are closed on the word the model flags as last in its period. Each such total is checked against the duty that the model holds for that period.

// File: rtl/ser_pwm_pkg.sv
package ser_pwm_pkg;

    // Direction of the period counter; both yield the same waveform.
    typedef enum logic {
        CNT_DOWN = 1'b0,
        CNT_UP   = 1'b1
    } cnt_dir_e;

    // Down form: counter holds the position of lane 0, lane k sits k below.
    function automatic logic lane_on_down(logic [31:0] duty,
                                          logic [31:0] pos_cnt,
                                          logic [31:0] lane);
        return duty > (pos_cnt - lane);
    endfunction

    // Up form: counter holds the elapsed steps; add offsets instead.
    function automatic logic lane_on_up(logic [31:0] duty,
                                        logic [31:0] up_cnt,
                                        logic [31:0] lane,
                                        logic [31:0] period);
        return (duty + up_cnt + lane) >= period;
    endfunction

endpackage

// File: rtl/ser_pwm_period_ctr.sv
module ser_pwm_period_ctr
    import ser_pwm_pkg::*;
#(
    parameter int       RATIO  = 4,
    parameter int       PERIOD = 65536,
    parameter cnt_dir_e DIR    = CNT_DOWN,
    parameter int       CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(RATIO);

    logic [CNT_W-1:0] cnt_q;

    generate
        if (DIR == CNT_DOWN) begin : g_down
            localparam logic [CNT_W-1:0] START = CNT_W'(PERIOD - 1);
            localparam logic [CNT_W-1:0] LAST  = CNT_W'(RATIO - 1);
            always_ff @(posedge clk) begin
                if (rst || (cnt_q == LAST)) cnt_q <= START;
                else                        cnt_q <= cnt_q - STEP;
            end
            assign wrap = (cnt_q == LAST);
        end else begin : g_up
            localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - RATIO);
            always_ff @(posedge clk) begin
                if (rst || (cnt_q == LAST)) cnt_q <= '0;
                else                        cnt_q <= cnt_q + STEP;
            end
            assign wrap = (cnt_q == LAST);
        end
    endgenerate

    assign cnt = cnt_q;

endmodule

// File: rtl/ser_pwm_duty_hold.sv
module ser_pwm_duty_hold #(
    parameter int DUTY_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic              load_en,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [DUTY_W-1:0] duty_q
);

    // Only the period boundary may change the value in use.
    always_ff @(posedge clk) begin
        if (rst)                  duty_q <= '0;
        else if (wrap && load_en) duty_q <= duty_in;
    end

endmodule

// File: rtl/ser_pwm_lane_cmp.sv
module ser_pwm_lane_cmp
    import ser_pwm_pkg::*;
#(
    parameter int       RATIO  = 4,
    parameter int       PERIOD = 65536,
    parameter cnt_dir_e DIR    = CNT_DOWN,
    parameter int       CNT_W  = 16,
    parameter int       DUTY_W = 17
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DUTY_W-1:0] duty_q,
    output logic [RATIO-1:0]  lane_on
);

    logic [31:0] duty_x;
    logic [31:0] cnt_x;

    assign duty_x = 32'(duty_q);
    assign cnt_x  = 32'(cnt);

    for (genvar k = 0; k < RATIO; k++) begin : g_lane
        if (DIR == CNT_DOWN) begin : g_dn
            assign lane_on[k] = lane_on_down(duty_x, cnt_x, 32'(k));
        end else begin : g_upc
            assign lane_on[k] = lane_on_up(duty_x, cnt_x, 32'(k), 32'(PERIOD));
        end
    end

endmodule

// File: rtl/ser_pwm_gen.sv
module ser_pwm_gen
    import ser_pwm_pkg::*;
#(
    parameter int       RATIO  = 4,
    parameter int       PERIOD = 65536,
    parameter cnt_dir_e DIR    = CNT_DOWN,
    parameter int       DUTY_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              load_en,
    output logic [RATIO-1:0]  pwm_word
);

    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [DUTY_W-1:0] duty_q;
    logic [RATIO-1:0]  lane_on;

    ser_pwm_period_ctr #(
        .RATIO (RATIO),
        .PERIOD(PERIOD),
        .DIR   (DIR),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk (clk),
        .rst (rst),
        .cnt (cnt),
        .wrap(wrap)
    );

    ser_pwm_duty_hold #(
        .DUTY_W(DUTY_W)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .wrap   (wrap),
        .load_en(load_en),
        .duty_in(duty_in),
        .duty_q (duty_q)
    );

    ser_pwm_lane_cmp #(
        .RATIO (RATIO),
        .PERIOD(PERIOD),
        .DIR   (DIR),
        .CNT_W (CNT_W),
        .DUTY_W(DUTY_W)
    ) u_cmp (
        .cnt    (cnt),
        .duty_q (duty_q),
        .lane_on(lane_on)
    );

    // One register stage toward the serializer's parallel input.
    always_ff @(posedge clk) begin
        if (rst) pwm_word <= '0;
        else     pwm_word <= lane_on;
    end

endmodule

// File: rtl/ser_pwm_gen_chk.sv
module ser_pwm_gen_chk #(
    parameter int RATIO  = 4,
    parameter int PERIOD = 65536,
    parameter int DUTY_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              load_en,
    input logic [DUTY_W-1:0] duty_in,
    input logic [DUTY_W-1:0] duty_q,
    input logic              wrap,
    input logic [RATIO-1:0]  pwm_word
);

    localparam int WORDS = PERIOD / RATIO;

    int unsigned gap;

    always_ff @(posedge clk) begin
        if (rst || wrap) gap <= 0;
        else             gap <= gap + 1;
    end

    p_rst_zero_r1: assert property (@(posedge clk)
        rst |=> (pwm_word == '0));

    p_thermo_r2: assert property (@(posedge clk) disable iff (rst)
        ((RATIO'(pwm_word << 1)) & ~pwm_word) == '0);

    p_stay_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(wrap) && pwm_word[RATIO-1]) |=> (&pwm_word));

    p_hold_mid_r4: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(duty_q));

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wrap && load_en) |=> (duty_q == $past(duty_in)));

    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wrap && !load_en) |=> $stable(duty_q));

    p_zero_duty_r6: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |=> (pwm_word == '0));

    p_full_duty_r7: assert property (@(posedge clk) disable iff (rst)
        (32'(duty_q) >= PERIOD) |=> (&pwm_word));

    p_period_len_r10: assert property (@(posedge clk) disable iff (rst)
        wrap == (gap == WORDS - 1));

endmodule

bind ser_pwm_gen ser_pwm_gen_chk #(
    .RATIO (RATIO),
    .PERIOD(PERIOD),
    .DUTY_W(DUTY_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .duty_in (duty_in),
    .duty_q  (duty_q),
    .wrap    (wrap),
    .pwm_word(pwm_word)
);

// File: tb/ser_pwm_gen_tb_top.sv
`timescale 1ns/1ps

// Behavioural reference: step index bookkeeping only.
module ser_pwm_ref #(
    parameter int N = 4,
    parameter int P = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  int           duty,
    output logic [N-1:0] exp_word,
    output logic         last_word,
    output int           exp_held
);
    int idx;
    int held;

    always @(posedge clk) begin
        if (rst) begin
            idx = 0; held = 0; exp_word = '0; last_word = 0; exp_held = 0;
        end else begin
            exp_held = (held > P) ? P : held;
            for (int k = 0; k < N; k++)
                exp_word[k] = ((idx * N + k) >= (P - exp_held));
            last_word = (idx == P / N - 1);
            if (last_word) begin
                idx = 0;
                if (load_en) held = duty;
            end else begin
                idx++;
            end
        end
    end
endmodule

module ser_pwm_gen_tb_top;
    import ser_pwm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT_CYC = 20000;

    logic clk = 0;
    logic rst = 1;
    logic load_en = 1;
    int   duty_v = 0;
    int   duty_odd;
    logic [8:0] d9;
    logic [7:0] d8;

    logic [3:0] w_dn, w_up, e_dn, e_up;
    logic [4:0] w_od, e_od;
    logic lw_dn, lw_up, lw_od;
    int   h_dn, h_up, h_od;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int acc_dn = 0, acc_up = 0, acc_od = 0;
    bit done = 0;
    string phase = "R1 reset";

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc++;

    assign duty_odd = (duty_v > 255) ? 255 : duty_v;
    assign d9 = 9'(duty_v);
    assign d8 = 8'(duty_odd);

    ser_pwm_gen #(.RATIO(4), .PERIOD(256), .DIR(CNT_DOWN)) dut_i (
        .clk(clk), .rst(rst), .duty_in(d9), .load_en(load_en), .pwm_word(w_dn));
    ser_pwm_gen #(.RATIO(4), .PERIOD(256), .DIR(CNT_UP)) dut_up_i (
        .clk(clk), .rst(rst), .duty_in(d9), .load_en(load_en), .pwm_word(w_up));
    ser_pwm_gen #(.RATIO(5), .PERIOD(250), .DIR(CNT_DOWN)) dut_odd_i (
        .clk(clk), .rst(rst), .duty_in(d8), .load_en(load_en), .pwm_word(w_od));

    ser_pwm_ref #(.N(4), .P(256)) ref_dn (
        .clk(clk), .rst(rst), .load_en(load_en), .duty(duty_v),
        .exp_word(e_dn), .last_word(lw_dn), .exp_held(h_dn));
    ser_pwm_ref #(.N(4), .P(256)) ref_up (
        .clk(clk), .rst(rst), .load_en(load_en), .duty(duty_v),
        .exp_word(e_up), .last_word(lw_up), .exp_held(h_up));
    ser_pwm_ref #(.N(5), .P(250)) ref_od (
        .clk(clk), .rst(rst), .load_en(load_en), .duty(duty_odd),
        .exp_word(e_od), .last_word(lw_od), .exp_held(h_od));

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] cyc %0d: got 0x%0h expected 0x%0h",
                     tag, phase, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Compare on the falling edge, after the rising edge that updated both.
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            if (rst) begin
                check("R1 reset word", int'(w_dn), 0);
                check("R1 reset word up", int'(w_up), 0);
                check("R1 reset word ratio5", int'(w_od), 0);
                acc_dn = 0; acc_up = 0; acc_od = 0;
            end else begin
                check("R2 word", int'(w_dn), int'(e_dn));
                check("R8 up-count word", int'(w_up), int'(e_up));
                check("R8 up equals down", int'(w_up), int'(w_dn));
                check("R9 ratio5 word", int'(w_od), int'(e_od));
                acc_dn += $countones(w_dn);
                acc_up += $countones(w_up);
                acc_od += $countones(w_od);
                if (lw_dn) begin check("R3/R10 period ones", acc_dn, h_dn); acc_dn = 0; end
                if (lw_up) begin check("R3/R8 period ones", acc_up, h_up); acc_up = 0; end
                if (lw_od) begin check("R3/R9 period ones", acc_od, h_od); acc_od = 0; end
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        duty_v = 77;
        run(6);
        rst = 0; phase = "R1 first period";      run(64);
        phase = "R2 duty 77";                     run(200);
        phase = "R4 mid-period change";
        duty_v = 130; run(20);
        duty_v = 10;  run(20);
        duty_v = 200; run(150);
        phase = "R5 load disabled";
        load_en = 0; duty_v = 5; run(200);
        load_en = 1;
        phase = "R6 full duty";   duty_v = 256; run(200);
        phase = "R6 zero duty";   duty_v = 0;   run(200);
        phase = "R7 over range";  duty_v = 400; run(200);
        phase = "R2 duty 1";      duty_v = 1;   run(150);
        phase = "R2 duty 255";    duty_v = 255; run(150);
        phase = "R9 duty 3";      duty_v = 3;   run(150);
        phase = "R1 reset again"; rst = 1; duty_v = 90; run(5);
        rst = 0; phase = "R1 first period again"; run(120);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * TIMEOUT_CYC);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule